// File: doc/BRIEF.md
# Strict-Priority Address-Event Queue

This block buffers address-event packets between a producer and a consumer. Every packet carries an event address, a priority class and a critical flag. Each class has its own bounded first-in first-out store. The output always offers the oldest packet of the non-empty class with the smallest class number. Class 0 therefore overtakes everything, and packets that share a class leave in the order they arrived.

Both sides use a valid/ready handshake. The input is not ready while the store of the offered class is full, except when that same class is being drained in the same cycle. In drop mode, a packet offered while not ready is thrown away and a sticky drop trap is raised. Outside drop mode the producer simply holds the packet.

A second sticky trap watches latency. Every stored entry ages by one per clock. If the head entry of any class is critical and its age has reached the programmed limit without being delivered, the deadline trap is raised. Both traps stay set until a clear input is pulsed.

Top module: `evt_prio_queue`

## Requirements
- R1: When `out_valid` is 1, the packet offered comes from the non-empty class with the smallest class number; `out_valid` is 0 only when every class is empty.
- R2: Packets within one class are offered in the order in which they were accepted.
- R3: Each class holds at most DEPTH packets (default 4). `in_ready` is 0 when the class selected by `in_prio` holds DEPTH packets, unless R7 applies.
- R4: With `drop_en`=1, a packet offered with `in_valid`=1 and `in_ready`=0 is discarded and `drop_trap` reads 1 from the next cycle on. With `drop_en`=0 the same offer is not stored and leaves `drop_trap` unchanged.
- R5: Both traps are sticky: once set, a trap stays 1 until a cycle with `trap_clear`=1. A new trap event in the clear cycle wins, and the trap stays 1.
- R6: Entry age is the number of clock edges since the entry was written, saturating at 2^AGE_W-1. If, in some cycle, a class head is critical, its age is at least `age_limit`, and it is not popped in that cycle, then `deadline_trap` is 1 from the next cycle on.
- R7: A push to a full class and a pop from that same class in one cycle are both accepted. `in_ready` is 1 in that cycle.
- R8: After reset, `out_valid`=0, `in_ready`=1, `drop_trap`=0 and `deadline_trap`=0.
- R9: `out_prio` gives the class number of the offered packet, and `out_crit` gives its critical flag as it was pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Producer offers a packet |
| in_ready | output | 1 | Offered packet can be stored this cycle |
| in_addr | input | ADDR_W | Event address of the offered packet |
| in_prio | input | PRIO_W | Priority class of the offered packet; 0 is most urgent |
| in_crit | input | 1 | Offered packet is deadline-critical |
| out_valid | output | 1 | A packet is offered to the consumer |
| out_ready | input | 1 | Consumer takes the offered packet |
| out_addr | output | ADDR_W | Event address of the offered packet |
| out_prio | output | PRIO_W | Class of the offered packet |
| out_crit | output | 1 | Critical flag of the offered packet |
| drop_en | input | 1 | Discard packets offered while not ready, and record the loss |
| age_limit | input | AGE_W | Age at which a waiting critical head counts as late |
| trap_clear | input | 1 | Clears both sticky traps |
| drop_trap | output | 1 | Sticky: a packet was discarded |
| deadline_trap | output | 1 | Sticky: a critical packet overstayed its limit |

## Verification
Two collisions matter most. The first is a push into a class that is full while the consumer drains that same class. The bench sets this up by filling one class with nothing else queued and then offering a packet with `out_ready` high. The outcome is judged from `in_ready` and from the order in which the packets later leave. The second is a drop event in the same cycle as `trap_clear`: the trap must remain set afterwards. A reference model of per-class queues, ages and traps runs alongside the design. It predicts every output in each cycle, both in directed scenarios and in a long pseudo-random sweep with a slow consumer, where overtaking, full classes, drops and deadline expiries mix freely.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int TRAP_N = 2;
  typedef enum logic [0:0] {
    TRAP_DROP     = 1'b0,
    TRAP_DEADLINE = 1'b1
  } trap_idx_e;
endpackage

// File: rtl/evq_class_fifo.sv
module evq_class_fifo #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  parameter int AGE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              push_crit_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_crit_o,
  output logic [AGE_W-1:0]  head_age_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic              crit_q [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];
  logic [AGE_W-1:0]  age_d  [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    rd_d  = pop_i  ? rd_q + PTR_W'(1) : rd_q;
    wr_d  = push_i ? wr_q + PTR_W'(1) : wr_q;
    cnt_d = cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && (wr_q == PTR_W'(i))) begin
        age_d[i] = '0;
      end else if (age_q[i] != AGE_MAX) begin
        age_d[i] = age_q[i] + AGE_W'(1);
      end else begin
        age_d[i] = age_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_d[i];
    end
  end

  // payload storage: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (push_i) begin
      addr_q[wr_q] <= push_addr_i;
      crit_q[wr_q] <= push_crit_i;
    end
  end

  assign head_addr_o = addr_q[rd_q];
  assign head_crit_o = crit_q[rd_q];
  assign head_age_o  = age_q[rd_q];
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |-> pop_i)
    else $error("push into full class without pop");

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o)
    else $error("pop from empty class");

  assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && !pop_i) |=> $stable(head_addr_o))
    else $error("head changed without a pop");

  assert_age_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && !pop_i && head_age_o != AGE_MAX) |=> (head_age_o == $past(head_age_o) + AGE_W'(1)))
    else $error("head age did not advance");
endmodule

// File: rtl/evq_prio_pick.sv
module evq_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic found;

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign any_o = found;
endmodule

// File: rtl/evq_trap_regs.sv
module evq_trap_regs #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] trap_o
);
  logic [N-1:0] trap_d;

  always_comb begin
    trap_d = set_i | (trap_o & ~{N{clr_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_o <= '0;
    else        trap_o <= trap_d;
  end

  assert_trap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (($past(trap_o) & ~trap_o) == '0))
    else $error("trap fell without clear");

  assert_trap_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((trap_o & $past(set_i)) == $past(set_i)))
    else $error("trap event lost");
endmodule

// File: rtl/evt_prio_queue.sv
module evt_prio_queue #(
  parameter int ADDR_W = 8,
  parameter int PRIO_W = 2,
  parameter int DEPTH  = 4,
  parameter int AGE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic              in_crit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PRIO_W-1:0] out_prio,
  output logic              out_crit,
  input  logic              drop_en,
  input  logic [AGE_W-1:0]  age_limit,
  input  logic              trap_clear,
  output logic              drop_trap,
  output logic              deadline_trap
);
  import evq_pkg::*;

  localparam int NCLS = 1 << PRIO_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NCLS-1:0]   push_c, pop_c, empty_c, full_c, nonempty_c, grant_c, late_c;
  logic [ADDR_W-1:0] head_addr [NCLS];
  logic              head_crit [NCLS];
  logic [AGE_W-1:0]  head_age  [NCLS];
  logic [PRIO_W-1:0] sel;
  logic              any_ne, pop_ok, push_ok, drop_evt;
  logic [TRAP_N-1:0] trap_set, trap_q;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign push_c[g]     = push_ok && (in_prio == PRIO_W'(g));
    assign pop_c[g]      = pop_ok && grant_c[g];
    assign nonempty_c[g] = !empty_c[g];
    assign late_c[g]     = nonempty_c[g] && head_crit[g] &&
                           (head_age[g] >= age_limit) && !pop_c[g];

    evq_class_fifo #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .AGE_W(AGE_W)
    ) u_fifo (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .push_i      (push_c[g]),
      .push_addr_i (in_addr),
      .push_crit_i (in_crit),
      .pop_i       (pop_c[g]),
      .head_addr_o (head_addr[g]),
      .head_crit_o (head_crit[g]),
      .head_age_o  (head_age[g]),
      .empty_o     (empty_c[g]),
      .full_o      (full_c[g])
    );
  end

  evq_prio_pick #(.N(NCLS), .IDX_W(PRIO_W)) u_pick (
    .req_i   (nonempty_c),
    .grant_o (grant_c),
    .idx_o   (sel),
    .any_o   (any_ne)
  );

  assign out_valid = any_ne;
  assign out_addr  = head_addr[sel];
  assign out_crit  = head_crit[sel];
  assign out_prio  = sel;
  assign pop_ok    = out_valid && out_ready;

  assign in_ready  = !full_c[in_prio] || pop_c[in_prio];
  assign push_ok   = in_valid && in_ready;
  assign drop_evt  = in_valid && !in_ready && drop_en;

  always_comb begin
    trap_set                = '0;
    trap_set[TRAP_DROP]     = drop_evt;
    trap_set[TRAP_DEADLINE] = |late_c;
  end

  evq_trap_regs #(.N(TRAP_N)) u_traps (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (trap_set),
    .clr_i  (trap_clear),
    .trap_o (trap_q)
  );

  assign drop_trap     = trap_q[TRAP_DROP];
  assign deadline_trap = trap_q[TRAP_DEADLINE];

  assert_lowest_wins_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> ((nonempty_c & ((NCLS'(1) << out_prio) - NCLS'(1))) == '0))
    else $error("lower class bypassed");

  assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && full_c[in_prio] && out_valid && out_ready && out_prio == in_prio) |-> in_ready)
    else $error("push refused during same-class pop");

  assert_drop_recorded_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !in_ready && drop_en) |=> drop_trap)
    else $error("drop not trapped");
endmodule

// File: tb/evt_prio_queue_tb.sv
`timescale 1ns/1ps
module evt_prio_queue_tb;
  localparam int DEPTH = 4;
  localparam int NCLS  = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_crit, out_valid, out_ready, out_crit;
  logic [7:0] in_addr, out_addr, age_limit;
  logic [1:0] in_prio, out_prio;
  logic       drop_en, trap_clear, drop_trap, deadline_trap;

  always #2.5 clk = ~clk;

  evt_prio_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_prio(in_prio), .in_crit(in_crit),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_prio(out_prio), .out_crit(out_crit),
    .drop_en(drop_en), .age_limit(age_limit), .trap_clear(trap_clear),
    .drop_trap(drop_trap), .deadline_trap(deadline_trap)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int q_addr [NCLS][$];
  bit q_crit [NCLS][$];
  int q_age  [NCLS][$];
  bit m_drop = 0;
  bit m_dl   = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input int ia, input int ip, input bit ic,
                      input bit ordy, input bit den, input int lim, input bit clr);
    int c;
    bit e_ov, e_pop, e_rdy, dls, drs;
    @(negedge clk);
    in_valid = iv; in_addr = 8'(ia); in_prio = 2'(ip); in_crit = ic;
    out_ready = ordy; drop_en = den; age_limit = 8'(lim); trap_clear = clr;
    #1;
    c = -1;
    for (int k = 0; k < NCLS; k++) if (c < 0 && q_addr[k].size() > 0) c = k;
    e_ov  = (c >= 0);
    e_pop = e_ov && ordy;
    e_rdy = (q_addr[ip].size() < DEPTH) || (e_pop && c == ip);
    chk("R1", "out_valid", int'(out_valid), int'(e_ov));
    if (e_ov) begin
      chk("R2", "out_addr", int'(out_addr), q_addr[c][0]);
      chk("R9", "out_prio", int'(out_prio), c);
      chk("R9", "out_crit", int'(out_crit), int'(q_crit[c][0]));
    end
    chk("R3/R7", "in_ready", int'(in_ready), int'(e_rdy));
    chk("R4/R5", "drop_trap", int'(drop_trap), int'(m_drop));
    chk("R6", "deadline_trap", int'(deadline_trap), int'(m_dl));
    dls = 0;
    for (int k = 0; k < NCLS; k++)
      if (q_addr[k].size() > 0 && q_crit[k][0] && q_age[k][0] >= lim && !(e_pop && c == k))
        dls = 1;
    drs = iv && !e_rdy && den;
    if (e_pop) begin
      void'(q_addr[c].pop_front());
      void'(q_crit[c].pop_front());
      void'(q_age[c].pop_front());
    end
    for (int k = 0; k < NCLS; k++)
      for (int j = 0; j < q_age[k].size(); j++)
        if (q_age[k][j] < 255) q_age[k][j]++;
    if (iv && e_rdy) begin
      q_addr[ip].push_back(ia & 8'hff);
      q_crit[ip].push_back(ic);
      q_age[ip].push_back(0);
    end
    m_drop = drs | (m_drop & !clr);
    m_dl   = dls | (m_dl & !clr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    in_valid = 0; in_addr = 0; in_prio = 0; in_crit = 0; out_ready = 0;
    drop_en = 0; age_limit = 8'd255; trap_clear = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R8 reset state
    chk("R8", "out_valid", int'(out_valid), 0);
    chk("R8", "in_ready", int'(in_ready), 1);
    chk("R8", "drop_trap", int'(drop_trap), 0);
    chk("R8", "deadline_trap", int'(deadline_trap), 0);

    // R3, R4, R5: fill class 2, refuse without drop mode, then drop and hold the trap
    for (int i = 0; i < DEPTH; i++) step(1, 8'h20 + i, 2, 0, 0, 0, 255, 0);
    step(1, 8'h2f, 2, 0, 0, 0, 255, 0);   // not ready, no trap
    step(0, 0, 0, 0, 0, 0, 255, 0);
    step(1, 8'h2e, 2, 0, 0, 1, 255, 0);   // dropped, trap next
    step(0, 0, 0, 0, 0, 0, 255, 0);
    step(0, 0, 0, 0, 0, 0, 255, 0);       // sticky
    step(1, 8'h2d, 2, 0, 0, 1, 255, 1);   // drop with clear: set wins
    step(0, 0, 0, 0, 0, 0, 255, 1);       // clear
    step(0, 0, 0, 0, 0, 0, 255, 0);

    // R1: class 3 queued first, class 0 then overtakes; other class 2 still waiting
    step(1, 8'h31, 3, 0, 0, 0, 255, 0);
    step(1, 8'h01, 0, 1, 0, 0, 255, 0);
    step(1, 8'h02, 0, 0, 0, 0, 255, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 1, 0, 255, 0);

    // R7: full class 1 only, push and pop same cycle
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + i, 1, 0, 0, 0, 255, 0);
    step(1, 8'h1a, 1, 1, 1, 0, 255, 0);
    step(1, 8'h1b, 1, 0, 1, 0, 255, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 0, 255, 0);

    // R6: critical head waits past limit 5, then one delivered in time
    step(1, 8'h3c, 3, 1, 0, 0, 5, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 5, 0);
    step(0, 0, 0, 0, 1, 0, 5, 1);
    step(1, 8'h3d, 3, 1, 0, 0, 5, 0);
    step(0, 0, 0, 0, 0, 0, 5, 0);
    step(0, 0, 0, 0, 1, 0, 5, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 5, 0);

    // sweep: mixed classes, slow and fast consumer, drops, deadlines, clears
    r = 32'h1ace_b00f;
    for (int i = 0; i < 6000; i++) begin
      bit ordy;
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      ordy = ((i / 500) % 2 == 0) ? (r[20:19] != 2'b00) : (r[20:19] == 2'b00);
      step(r[0] | r[1], int'(r[15:8]), int'(r[17:16]), r[18], ordy, r[21],
           4 + int'(r[24:22]), r[29:25] == 5'd0);
    end
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 0, 255, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule